// File: doc/BRIEF.md
# Gapped Serial Overhead Port

This block connects the overhead bit slots of a framed DSL link to an external serial device. The framer announces each overhead slot with a one-cycle strobe and a slot index, separately for the transmit direction and the receive direction. On transmit, the block issues a clock pulse to the external device and samples the device's serial data on the rising edge of that pulse. It hands the bit to the framer for insertion. On receive, the block places each extracted bit on a serial data output and then issues a clock pulse for it. Both generated clocks pulse only for overhead slots, so they are gapped.

A per-slot routing mask marks which positions are user-defined. User-defined positions, plus one fixed remote-indicator position, travel over the serial port. Predefined positions take their transmit bit from the register path and are never shown on the receive output. A mode input turns the serial data path off. The start-of-frame flags in both directions keep running while it is off. The bits pass through unchanged; the block decodes no protocol.

Top module: `ovh_serial_port`

## Requirements
- R1: While rst_ni is low, both generated clocks, both start flags, tx_bit_o, tx_bit_vld_o and rx_sdata_o are low.
- R2: A strobe is sampled at clock edge E0. The matching clock output is then high for exactly the one cycle after edge E1 when the slot is routed, and is low in every other cycle. Two strobes must be at least two cycles apart.
- R3: A slot is routed when par_mode_i is 0 and either its route_mask_i bit is 1 (user-defined) or its index equals the remote-indicator index IND_IDX (default 7). A slot whose mask bit is 0 and whose index is not IND_IDX is not routed.
- R4: The start flag of a direction is high in the same cycle as that direction's clock pulse window (after E1) for a slot of index 0. This holds whether or not the slot is routed. It is low otherwise.
- R5: When par_mode_i is 1, no clock pulse is issued in either direction, rx_sdata_o keeps its value, and both start flags still operate.
- R6: tx_bit_vld_o is high for exactly one cycle after E1 of every transmit slot. tx_bit_o then equals tx_sdata_i as sampled at E1 (the rising edge of tx_sclk_o) for a routed slot, and tx_reg_bit_i as sampled at E0 otherwise.
- R7: For a routed receive slot, rx_sdata_o takes rx_bit_i unchanged at E0. The value stays stable through the rising edge of rx_sclk_o and holds until the next routed receive slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_mode_i | input | 1 | 1 disables the serial data path |
| route_mask_i | input | N_SLOTS | 1 marks a user-defined overhead position |
| tx_slot_i | input | 1 | Transmit overhead slot strobe |
| tx_idx_i | input | IDX_W | Transmit slot index within the frame |
| tx_reg_bit_i | input | 1 | Register-path bit for the transmit slot |
| tx_sdata_i | input | 1 | Serial data from the external device |
| tx_sclk_o | output | 1 | Gapped clock to the external data source |
| tx_sof_o | output | 1 | Transmit start-of-frame flag |
| tx_bit_o | output | 1 | Overhead bit handed to the framer |
| tx_bit_vld_o | output | 1 | tx_bit_o is valid |
| rx_slot_i | input | 1 | Receive overhead slot strobe |
| rx_idx_i | input | IDX_W | Receive slot index within the frame |
| rx_bit_i | input | 1 | Extracted overhead bit |
| rx_sclk_o | output | 1 | Gapped clock for the receive serial output |
| rx_sdata_o | output | 1 | Receive serial data |
| rx_sof_o | output | 1 | Receive start-of-frame flag |

## Verification
On every cycle, the assertions check the following. Each clock pulse and valid pulse traces back to a strobe two cycles earlier, with the port enabled. Pulses never last two cycles. Start flags follow only index-0 slots. Receive data does not move while its clock is high. Only the bench's scenarios can show the routing decision for each mask pattern and for the indicator position. They also show which source feeds each inserted bit, that received bit values arrive unchanged, and that receive data holds across unrouted and disabled slots.

// File: rtl/ovh_pkg.sv
package ovh_pkg;
  typedef struct packed {
    logic first;
    logic route;
    logic vld;
  } slot_stage_t;
endpackage

// File: rtl/ovh_route.sv
module ovh_route #(
  parameter int unsigned N_SLOTS = 48,
  parameter int unsigned IND_IDX = 7,
  parameter int unsigned IDX_W   = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0] mask_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               ser_en_i,
  output logic               route_o,
  output logic               first_o
);
  logic in_range;
  logic user_def;

  assign in_range = 32'(idx_i) < N_SLOTS;
  assign user_def = in_range && mask_i[idx_i];
  assign route_o  = ser_en_i && (user_def || (idx_i == IDX_W'(IND_IDX)));
  assign first_o  = (idx_i == '0);
endmodule

// File: rtl/ovh_slot_seq.sv
module ovh_slot_seq
  import ovh_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slot_i,
  input  logic        route_i,
  input  logic        first_i,
  output slot_stage_t st1_o,
  output logic        sclk_o,
  output logic        sof_o,
  output logic        done_o
);
  slot_stage_t st1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st1_q  <= '0;
      sclk_o <= 1'b0;
      sof_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      st1_q  <= '{first: first_i, route: route_i, vld: slot_i};
      sclk_o <= st1_q.vld && st1_q.route;
      sof_o  <= st1_q.vld && st1_q.first;
      done_o <= st1_q.vld;
    end
  end

  assign st1_o = st1_q;

  p_slot_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i |=> !slot_i);
  p_pulse_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> !sclk_o);
  p_pulse_origin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> ($past(slot_i, 2) && $past(route_i, 2)));
  p_sof_origin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> ($past(slot_i, 2) && $past(first_i, 2)));
endmodule

// File: rtl/ovh_tx_lane.sv
module ovh_tx_lane
  import ovh_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slot_i,
  input  logic route_i,
  input  logic first_i,
  input  logic par_mode_i,
  input  logic reg_bit_i,
  input  logic sdata_i,
  output logic sclk_o,
  output logic sof_o,
  output logic bit_o,
  output logic bit_vld_o
);
  slot_stage_t st1;
  logic        reg_q;

  ovh_slot_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slot_i  (slot_i),
    .route_i (route_i),
    .first_i (first_i),
    .st1_o   (st1),
    .sclk_o  (sclk_o),
    .sof_o   (sof_o),
    .done_o  (bit_vld_o)
  );

  // sdata_i is sampled on the edge where sclk_o rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= 1'b0;
      bit_o <= 1'b0;
    end else begin
      if (slot_i) reg_q <= reg_bit_i;
      if (st1.vld) bit_o <= st1.route ? sdata_i : reg_q;
      else         bit_o <= 1'b0;
    end
  end

  p_vld_origin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> $past(slot_i, 2));
  p_no_clk_par_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !$past(par_mode_i, 2));
endmodule

// File: rtl/ovh_rx_lane.sv
module ovh_rx_lane
  import ovh_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slot_i,
  input  logic route_i,
  input  logic first_i,
  input  logic par_mode_i,
  input  logic bit_i,
  output logic sclk_o,
  output logic sof_o,
  output logic sdata_o
);
  slot_stage_t st1;
  logic        done_unused;

  ovh_slot_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slot_i  (slot_i),
    .route_i (route_i),
    .first_i (first_i),
    .st1_o   (st1),
    .sclk_o  (sclk_o),
    .sof_o   (sof_o),
    .done_o  (done_unused)
  );

  // data leads the clock pulse by one cycle, changing while sclk_o is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sdata_o <= 1'b0;
    else if (slot_i && route_i)  sdata_o <= bit_i;
  end

  p_data_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && st1.vld == 1'b0) |-> $stable(sdata_o));
  p_hold_par_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(par_mode_i) |-> ($stable(sdata_o) && !sclk_o) or !$past(slot_i));
endmodule

// File: rtl/ovh_serial_port.sv
module ovh_serial_port #(
  parameter int unsigned N_SLOTS = 48,
  parameter int unsigned IND_IDX = 7,
  localparam int unsigned IDX_W  = $clog2(N_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               par_mode_i,
  input  logic [N_SLOTS-1:0] route_mask_i,
  input  logic               tx_slot_i,
  input  logic [IDX_W-1:0]   tx_idx_i,
  input  logic               tx_reg_bit_i,
  input  logic               tx_sdata_i,
  output logic               tx_sclk_o,
  output logic               tx_sof_o,
  output logic               tx_bit_o,
  output logic               tx_bit_vld_o,
  input  logic               rx_slot_i,
  input  logic [IDX_W-1:0]   rx_idx_i,
  input  logic               rx_bit_i,
  output logic               rx_sclk_o,
  output logic               rx_sdata_o,
  output logic               rx_sof_o
);
  localparam int unsigned N_DIR = 2;

  logic             ser_en;
  logic [IDX_W-1:0] idx   [N_DIR];
  logic [N_DIR-1:0] route;
  logic [N_DIR-1:0] first;

  assign ser_en = !par_mode_i;
  assign idx[0] = tx_idx_i;
  assign idx[1] = rx_idx_i;

  for (genvar d = 0; d < N_DIR; d++) begin : g_route
    ovh_route #(.N_SLOTS(N_SLOTS), .IND_IDX(IND_IDX), .IDX_W(IDX_W)) u_route (
      .mask_i   (route_mask_i),
      .idx_i    (idx[d]),
      .ser_en_i (ser_en),
      .route_o  (route[d]),
      .first_o  (first[d])
    );
  end

  ovh_tx_lane u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_i     (tx_slot_i),
    .route_i    (route[0]),
    .first_i    (first[0]),
    .par_mode_i (par_mode_i),
    .reg_bit_i  (tx_reg_bit_i),
    .sdata_i    (tx_sdata_i),
    .sclk_o     (tx_sclk_o),
    .sof_o      (tx_sof_o),
    .bit_o      (tx_bit_o),
    .bit_vld_o  (tx_bit_vld_o)
  );

  ovh_rx_lane u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_i     (rx_slot_i),
    .route_i    (route[1]),
    .first_i    (first[1]),
    .par_mode_i (par_mode_i),
    .bit_i      (rx_bit_i),
    .sclk_o     (rx_sclk_o),
    .sof_o      (rx_sof_o),
    .sdata_o    (rx_sdata_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!tx_sclk_o && !rx_sclk_o && !tx_sof_o && !rx_sof_o));
endmodule

// File: tb/sim_ovh_serial_port.sv
module sim_ovh_serial_port;
  localparam int unsigned N_SLOTS = 48;
  localparam int unsigned IND_IDX = 7;
  localparam int unsigned IDX_W   = $clog2(N_SLOTS);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               par_mode = 1'b0;
  logic [N_SLOTS-1:0] mask = '0;
  logic               tx_slot = 1'b0, tx_reg = 1'b0, tx_sd = 1'b0;
  logic [IDX_W-1:0]   tx_idx = '0, rx_idx = '0;
  logic               rx_slot = 1'b0, rx_bit = 1'b0;
  logic tx_sclk, tx_sof, tx_bit, tx_vld, rx_sclk, rx_sd, rx_sof;

  int errors = 0;
  int checks = 0;
  logic rx_model = 1'b0;

  always #4 clk = ~clk;

  ovh_serial_port #(.N_SLOTS(N_SLOTS), .IND_IDX(IND_IDX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .par_mode_i(par_mode), .route_mask_i(mask),
    .tx_slot_i(tx_slot), .tx_idx_i(tx_idx), .tx_reg_bit_i(tx_reg),
    .tx_sdata_i(tx_sd), .tx_sclk_o(tx_sclk), .tx_sof_o(tx_sof),
    .tx_bit_o(tx_bit), .tx_bit_vld_o(tx_vld),
    .rx_slot_i(rx_slot), .rx_idx_i(rx_idx), .rx_bit_i(rx_bit),
    .rx_sclk_o(rx_sclk), .rx_sdata_o(rx_sd), .rx_sof_o(rx_sof)
  );

  function automatic logic routed(logic par, logic [N_SLOTS-1:0] m, logic [IDX_W-1:0] i);
    return !par && ((32'(i) < N_SLOTS && m[i]) || 32'(i) == IND_IDX);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one slot pair: strobes at E0, checks after E0 and after E1
  task automatic run_slot(logic txs, logic [IDX_W-1:0] ti, logic treg, logic tsd,
                          logic rxs, logic [IDX_W-1:0] ri, logic rb);
    logic tr, rr, exp_rx;
    tx_slot = txs; tx_idx = ti; tx_reg = treg; tx_sd = tsd;
    rx_slot = rxs; rx_idx = ri; rx_bit = rb;
    tr = txs && routed(par_mode, mask, ti);
    rr = rxs && routed(par_mode, mask, ri);
    @(negedge clk);
    tx_slot = 1'b0; rx_slot = 1'b0;
    chk("R2 tx gap", tx_sclk, 1'b0);
    chk("R2 rx gap", rx_sclk, 1'b0);
    exp_rx = rr ? rb : rx_model;
    chk("R7 rx data lead", rx_sd, exp_rx);
    @(negedge clk);
    chk("R2/R3/R5 tx pulse", tx_sclk, tr);
    chk("R2/R3/R5 rx pulse", rx_sclk, rr);
    chk("R4 tx sof", tx_sof, txs && ti == '0);
    chk("R4 rx sof", rx_sof, rxs && ri == '0);
    chk("R6 tx vld", tx_vld, txs);
    if (txs) chk("R6 tx bit", tx_bit, tr ? tsd : treg);
    chk("R7 rx data held", rx_sd, exp_rx);
    rx_model = exp_rx;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx_sclk", tx_sclk, 1'b0); chk("R1 rx_sclk", rx_sclk, 1'b0);
    chk("R1 tx_sof", tx_sof, 1'b0);   chk("R1 rx_sof", rx_sof, 1'b0);
    chk("R1 tx_bit", tx_bit, 1'b0);   chk("R1 tx_vld", tx_vld, 1'b0);
    chk("R1 rx_sd", rx_sd, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 indicator routed with empty mask; predefined not routed
    mask = '0;
    run_slot(1'b1, IDX_W'(IND_IDX), 1'b0, 1'b1, 1'b1, IDX_W'(IND_IDX), 1'b1);
    run_slot(1'b1, IDX_W'(3), 1'b1, 1'b0, 1'b1, IDX_W'(3), 1'b0);
    // R3 user-defined slot routed
    mask[12] = 1'b1;
    run_slot(1'b1, IDX_W'(12), 1'b1, 1'b0, 1'b1, IDX_W'(12), 1'b0);
    // R5 disabled: index 0 still flags, no pulse, data held
    par_mode = 1'b1; mask = '1;
    run_slot(1'b1, '0, 1'b1, 1'b0, 1'b1, '0, 1'b1);
    run_slot(1'b1, IDX_W'(IND_IDX), 1'b0, 1'b1, 1'b1, IDX_W'(IND_IDX), 1'b1);
    par_mode = 1'b0;
    // R4 index 0 unrouted still flags
    mask = '0;
    run_slot(1'b1, '0, 1'b1, 1'b0, 1'b1, '0, 1'b1);
    // idle cycle pair
    run_slot(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0);

    for (int n = 0; n < 600; n++) begin
      logic [IDX_W-1:0] ti, ri;
      if (n % 48 == 0) mask = {$urandom, $urandom};
      par_mode = ($urandom % 10) == 0;
      ti = ($urandom % 6 == 0) ? '0 : IDX_W'($urandom % N_SLOTS);
      ri = ($urandom % 6 == 0) ? '0 : IDX_W'($urandom % N_SLOTS);
      run_slot(($urandom % 4) != 0, ti, 1'($urandom), 1'($urandom),
               ($urandom % 4) != 0, ri, 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule